// File: doc/BRIEF.md
# Byte-Vector Squared Distance Accumulator

This block is a custom-instruction datapath for a processor pipeline. It computes the squared Euclidean distance between two vectors of unsigned 8-bit samples. Each operand is one 64-bit word that carries eight samples, and the block handles them as eight parallel lanes. For each lane it forms the signed difference and squares its magnitude. The eight squares then go through a binary adder tree, and the tree total is added into a 32-bit accumulator.

A single pipeline register divides the work into two stages. The first stage produces the differences and squares. The second stage reduces the squares and updates the accumulator.

The processor presents an operand pair together with a valid strobe, and it may do so on every clock cycle. Before a new vector it raises a clear strobe, which restarts the running sum. Long vectors are split across many operand words and summed in the accumulator, which saturates at its maximum value instead of wrapping.

Top module: `l2dist_unit`

## Requirements
- R1: While reset is held, and after it is released with no activity, `result_o` reads 0 and `res_valid_o` reads 0.
- R2: Sample i of each operand sits in bits [8i+7:8i] and is unsigned. The distance of a pair is the sum over the eight lanes of (a_i - b_i) squared, whichever sample of a lane is the larger.
- R3: A pair sampled on rising edge k is reflected in `result_o` after edge k+1. `res_valid_o` is high for exactly that one cycle for each accepted pair, and low in cycles that follow no accepted pair.
- R4: Pairs can be accepted on consecutive cycles without a gap, and each one produces its own valid cycle and accumulator update.
- R5: A pair accepted without clear adds its distance to the previous `result_o`.
- R6: A pair accepted together with clear sets `result_o` to that pair's distance alone.
- R7: Clear without a valid pair sets `result_o` to 0 after the same latency as a pair, and `res_valid_o` stays low.
- R8: When the sum would exceed 0xFFFFFFFF, `result_o` becomes 0xFFFFFFFF and stays there under further pairs until it is cleared.
- R9: With neither valid nor clear asserted, `result_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clear_i | input | 1 | Restart the running sum |
| op_valid_i | input | 1 | Operand pair is present this cycle |
| op_a_i | input | 64 | First operand, eight unsigned bytes |
| op_b_i | input | 64 | Second operand, eight unsigned bytes |
| res_valid_o | output | 1 | One-cycle strobe for each accepted pair |
| result_o | output | 32 | Accumulated squared distance |

## Verification
A clear and an accumulation can land in the same cycle. When a pair arrives with clear raised, the accumulator must drop its old value and load only the new distance. When a pair arrives one cycle after a clear, it must add onto zero and not onto the value held before the clear.

The random phase raises clear on some cycles with valid and on some without, inside streams of back-to-back pairs. A directed sequence also places clear-only, clear-with-pair and plain pairs on adjacent cycles. Every cycle, both outputs are compared with a bench model that updates its sum in request order and delays the result by the pipeline depth.

// File: rtl/l2dist_pkg.sv
package l2dist_pkg;
  localparam int unsigned L2_LANES  = 8;
  localparam int unsigned L2_ELEM_W = 8;
  localparam int unsigned L2_ACC_W  = 32;
endpackage

// File: rtl/l2dist_lane.sv
module l2dist_lane #(
  parameter int unsigned ELEM_W = 8
) (
  input  logic [ELEM_W-1:0]   a_i,
  input  logic [ELEM_W-1:0]   b_i,
  output logic [2*ELEM_W-1:0] sq_o
);
  localparam int unsigned SQ_W = 2 * ELEM_W;

  logic [ELEM_W:0]   diff;
  logic [ELEM_W:0]   diff_neg;
  logic [ELEM_W-1:0] mag;
  logic [SQ_W-1:0]   mag_w;

  always_comb begin
    diff     = {1'b0, a_i} - {1'b0, b_i};
    diff_neg = -diff;
    mag      = diff[ELEM_W] ? diff_neg[ELEM_W-1:0] : diff[ELEM_W-1:0];
    mag_w    = {{ELEM_W{1'b0}}, mag};
    sq_o     = mag_w * mag_w;
  end
endmodule

// File: rtl/l2dist_reduce.sv
module l2dist_reduce #(
  parameter int unsigned LANES = 8,
  parameter int unsigned SQ_W  = 16,
  parameter int unsigned ACC_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_i,
  input  logic                  clr_i,
  input  logic [LANES*SQ_W-1:0] sq_i,
  output logic                  valid_o,
  output logic [ACC_W-1:0]      acc_o
);
  localparam int unsigned SUM_W = SQ_W + $clog2(LANES);
  localparam int unsigned NODES = 2 * LANES - 1;
  localparam int unsigned PAD_W = ACC_W + 1 - SUM_W;

  logic [SUM_W-1:0] node [NODES];

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_leaf
      assign node[LANES-1+gi] = {{(SUM_W-SQ_W){1'b0}}, sq_i[gi*SQ_W +: SQ_W]};
    end
    for (gi = 0; gi < LANES - 1; gi++) begin : g_node
      assign node[gi] = node[2*gi+1] + node[2*gi+2];
    end
  endgenerate

  logic [ACC_W:0]   sum_ext;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] acc_q;
  logic             acc_en;
  logic             vld_q;

  always_comb begin
    sum_ext = {1'b0, acc_q} + {{PAD_W{1'b0}}, node[0]};
    acc_en  = valid_i | clr_i;
    acc_d   = acc_q;
    if (clr_i) begin
      acc_d = valid_i ? {{(PAD_W-1){1'b0}}, node[0]} : '0;
    end else if (valid_i) begin
      acc_d = sum_ext[ACC_W] ? {ACC_W{1'b1}} : sum_ext[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= valid_i;
  end

  assign acc_o   = acc_q;
  assign valid_o = vld_q;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !clr_i) |=> $stable(acc_q));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !clr_i) |=> (acc_q >= $past(acc_q)));
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !valid_i) |=> (acc_q == '0));
endmodule

// File: rtl/l2dist_unit.sv
module l2dist_unit
  import l2dist_pkg::*;
#(
  parameter int unsigned LANES  = L2_LANES,
  parameter int unsigned ELEM_W = L2_ELEM_W,
  parameter int unsigned ACC_W  = L2_ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    op_valid_i,
  input  logic [LANES*ELEM_W-1:0] op_a_i,
  input  logic [LANES*ELEM_W-1:0] op_b_i,
  output logic                    res_valid_o,
  output logic [ACC_W-1:0]        result_o
);
  localparam int unsigned SQ_W   = 2 * ELEM_W;
  localparam int unsigned SQV_W  = LANES * SQ_W;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [SQV_W-1:0] sq_d;

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      l2dist_lane #(.ELEM_W(ELEM_W)) u_lane (
        .a_i  (op_a_i[gl*ELEM_W +: ELEM_W]),
        .b_i  (op_b_i[gl*ELEM_W +: ELEM_W]),
        .sq_o (sq_d[gl*SQ_W +: SQ_W])
      );
    end
  endgenerate

  logic [SQV_W-1:0] sq_q;
  logic             s1_vld_q, s1_clr_q;
  logic             sq_en;

  always_comb sq_en = op_valid_i;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sq_q <= '0;
    end else if (sq_en) begin
      sq_q <= sq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld_q <= 1'b0;
      s1_clr_q <= 1'b0;
    end else begin
      s1_vld_q <= op_valid_i;
      s1_clr_q <= clear_i;
    end
  end

  l2dist_reduce #(.LANES(LANES), .SQ_W(SQ_W), .ACC_W(ACC_W)) u_reduce (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .valid_i (s1_vld_q),
    .clr_i   (s1_clr_q),
    .sq_i    (sq_q),
    .valid_o (res_valid_o),
    .acc_o   (result_o)
  );

  assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid_i |-> ##2 res_valid_o);
  assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid_i |-> ##2 !res_valid_o);
endmodule

// File: tb/l2dist_unit_test.sv
module l2dist_unit_test;
  logic        clk;
  logic        rst_n;
  logic        clear_i;
  logic        op_valid_i;
  logic [63:0] op_a_i;
  logic [63:0] op_b_i;
  logic        res_valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl_acc;
  logic        hv0, hv1;
  logic [31:0] hr0, hr1;

  l2dist_unit uut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .op_valid_i(op_valid_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .res_valid_o(res_valid_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] pair_dist(input logic [63:0] a, input logic [63:0] b);
    int s = 0;
    for (int i = 0; i < 8; i++) begin
      int d = int'(a[i*8 +: 8]) - int'(b[i*8 +: 8]);
      s += d * d;
    end
    return 32'(s);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic c, input logic [63:0] a,
                      input logic [63:0] b, input string tag);
    logic [63:0] t;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, res_valid_o}, {31'd0, hv1});
    check({tag, " result"}, result_o, hr1);
    op_valid_i = v; clear_i = c; op_a_i = a; op_b_i = b;
    if (c) mdl_acc = v ? pair_dist(a, b) : 32'd0;
    else if (v) begin
      t = {32'd0, mdl_acc} + {32'd0, pair_dist(a, b)};
      mdl_acc = (t > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : t[31:0];
    end
    hv1 = hv0; hr1 = hr0;
    hv0 = v;   hr0 = mdl_acc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; clear_i = 1'b0; op_valid_i = 1'b0; op_a_i = '0; op_b_i = '0;
    mdl_acc = '0; hv0 = 0; hv1 = 0; hr0 = '0; hr1 = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, res_valid_o}, 32'd0);
    check("R1 reset result", result_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle result", result_o, 32'd0);
    // R2 R6: clear with a full-swing pair, then a pair with a<b lanes
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R6");
    step(1, 0, 64'h0001_0203_0405_0607, 64'h8070_6050_4030_2010, "R2");
    step(1, 0, 64'h10FF_00A0_0580_7F01, 64'hFF10_A000_8005_017F, "R5");
    step(0, 0, 64'h0, 64'h0, "R9");
    step(0, 0, 64'h1234, 64'h9876, "R9");
    step(0, 0, 64'h0, 64'h0, "R9");
    // R7 clear only, then pair on the next cycle adds onto zero
    step(0, 1, 64'hFF, 64'h0, "R7");
    step(1, 0, 64'h0000_0000_0000_0003, 64'h0, "R7");
    step(1, 1, 64'h0000_0000_0000_0005, 64'h0, "R6");
    step(0, 1, 64'h0, 64'h0, "R7");
    step(1, 0, 64'h0000_0000_0000_0500, 64'h0000_0000_0000_0700, "R2");
    step(0, 0, 64'h0, 64'h0, "R3");
    step(0, 0, 64'h0, 64'h0, "R3");
    // R4 random traffic with back-to-back pairs and occasional clears
    for (int i = 0; i < 3000; i++) begin
      logic v, c;
      v = ($urandom() % 4) != 0;
      c = ($urandom() % 16) == 0;
      step(v, c, {$urandom(), $urandom()}, {$urandom(), $urandom()}, "R4");
    end
    // R8 saturation with max-distance pairs
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R6");
    for (int i = 0; i < 8400; i++) begin
      step(1, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    end
    step(0, 0, 64'h0, 64'h0, "R8");
    step(0, 0, 64'h0, 64'h0, "R8");
    check("R8 saturated", result_o, 32'hFFFF_FFFF);
    step(0, 1, 64'h0, 64'h0, "R7");
    step(0, 0, 64'h0, 64'h0, "R7");
    step(0, 0, 64'h0, 64'h0, "R7");
    check("R7 cleared", result_o, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule